// File: doc/BRIEF.md
# Non-Blocking Flow Aggregation Cache

This block holds per-flow aggregation state for a packet stream, one lookup per clock. Each request carries a flow key, formed from the connection 5-tuple plus the queue identifier, and an update operand. The key picks one set of a small set-associative store. A request whose key is resident adds its operand to the stored value and bumps the entry's packet count. A request whose key is absent installs the key with a fixed start value, so the pipeline never has to fetch anything.

When a set is full, the least recently used entry is pushed out. Its key, value and packet count go into an eviction queue that drains toward an external backing store, and nothing ever comes back from that store. The store can later merge each record into its own copy, because the record carries the count of updates the entry took while it was on chip. Requests are back-pressured only when the eviction queue is close to full. A flush command walks every entry, emits the valid ones and clears the store.

Top module: `kvc_top`

## Requirements
- R1: After reset, req_ready_o is 1, ev_valid_o is 0 and every entry is invalid, so a flush issued right after reset emits no record.
- R2: The set index bit j is the XOR of all key bits i with i mod IDX_W equal to j (IDX_W = log2 SETS). Keys that map to different sets never displace each other.
- R3: A hit adds req_op_i to the stored value modulo 2^VAL_W, increments the entry's count and emits no record.
- R4: A miss in a set with a free way fills the lowest-numbered free way with value INIT_VAL + req_op_i and count 1, and emits no record.
- R5: A miss in a full set emits one record {key, value, count} of the displaced entry and installs the new key as in R4.
- R6: Each way has an age from 0 (newest) to WAYS-1 (oldest); after reset way w has age w. An access to way s sets its age to 0 and raises by one every age below the old age of s. A full-set miss displaces the way of age WAYS-1.
- R7: A request that follows a request to the same set in the next cycle sees that earlier update.
- R8: With the eviction queue empty, a record caused by a request accepted on a rising edge is visible on the ev_ outputs after the next rising edge, and not before.
- R9: Records leave in the order they were created and none is lost. The queue is 8 deep, a record holds still while ev_ready_i is low, and req_ready_o is 0 while the queue holds 7 or more records.
- R10: A flush_i pulse makes the block visit every entry, one per cycle, set 0 first and ways in ascending order within a set. It emits a record for each valid entry, then leaves all entries invalid with their ages back at the reset values. req_ready_o is 0 for the whole walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high with req_valid_i |
| req_key_i | input | KEY_W | Flow key (5-tuple plus queue id) |
| req_op_i | input | VAL_W | Update operand |
| flush_i | input | 1 | Pulse starts a flush walk |
| ev_valid_o | output | 1 | Eviction record present |
| ev_ready_i | input | 1 | Backing store takes the record |
| ev_key_o | output | KEY_W | Evicted key |
| ev_val_o | output | VAL_W | Evicted value |
| ev_cnt_o | output | CNT_W | Updates applied since install |

## Verification
A request is taken on the rising edge where valid and ready are both high. Its set update is written, and any eviction is pushed, on the following edge, so a record shows on the ev_ outputs after that second edge. The bench drives inputs one time unit after each rising edge and samples at falling edges. A scoreboard model computes every record when its request is accepted, and a monitor compares records in order as they are popped. The R8 check samples ev_valid_o at the two falling edges after acceptance. The R9 ready check waits for the pipeline to settle before it samples.

// File: rtl/kvc_pkg.sv
package kvc_pkg;
  typedef enum logic {FL_IDLE, FL_WALK} fl_state_e;
endpackage

// File: rtl/kvc_hash.sv
module kvc_hash #(
  parameter int KEY_W = 48,
  parameter int IDX_W = 2
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [IDX_W-1:0] idx_o
);
  // fold key bits onto index lanes by position modulo IDX_W
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < KEY_W; i++) begin
      idx_o[i % IDX_W] = idx_o[i % IDX_W] ^ key_i[i];
    end
  end
endmodule

// File: rtl/kvc_way_sel.sv
module kvc_way_sel #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0]            match_i,
  input  logic [WAYS-1:0][AGE_W-1:0] age_i,
  output logic                       hit_o,
  output logic                       full_o,
  output logic [AGE_W-1:0]           sel_o,
  output logic [WAYS-1:0][AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS-1);

  logic [WAYS-1:0]  hit_v;
  logic [AGE_W-1:0] hit_w, free_w, old_w;

  assign hit_v  = valid_i & match_i;
  assign hit_o  = |hit_v;
  assign full_o = &valid_i;

  always_comb begin
    hit_w  = '0;
    free_w = '0;
    old_w  = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_v[w])            hit_w  = AGE_W'(w);
      if (!valid_i[w])         free_w = AGE_W'(w);
      if (age_i[w] == OLDEST)  old_w  = AGE_W'(w);
    end
  end

  assign sel_o = hit_o ? hit_w : (!full_o ? free_w : old_w);

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign age_o[w] = (AGE_W'(w) == sel_o)         ? '0 :
                      (age_i[w] < age_i[sel_o])    ? age_i[w] + 1'b1 :
                                                     age_i[w];
  end
endmodule

// File: rtl/kvc_fifo.sv
module kvc_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PTR_W-1:0]        rd_q, wr_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/kvc_top.sv
module kvc_top
  import kvc_pkg::*;
#(
  parameter int KEY_W      = 48,
  parameter int VAL_W      = 16,
  parameter int CNT_W      = 8,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int FIFO_DEPTH = 8,
  parameter logic [VAL_W-1:0] INIT_VAL = VAL_W'(16)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [KEY_W-1:0] req_key_i,
  input  logic [VAL_W-1:0] req_op_i,
  input  logic             flush_i,
  output logic             ev_valid_o,
  input  logic             ev_ready_i,
  output logic [KEY_W-1:0] ev_key_o,
  output logic [VAL_W-1:0] ev_val_o,
  output logic [CNT_W-1:0] ev_cnt_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int AGE_W = $clog2(WAYS);
  localparam int ENT   = SETS * WAYS;
  localparam int ENT_W = $clog2(ENT);
  localparam int EV_W  = KEY_W + VAL_W + CNT_W;
  localparam int FC_W  = $clog2(FIFO_DEPTH + 1);

  typedef struct packed {
    logic [WAYS-1:0]            v;
    logic [WAYS-1:0][KEY_W-1:0] k;
    logic [WAYS-1:0][VAL_W-1:0] val;
    logic [WAYS-1:0][CNT_W-1:0] cnt;
    logic [WAYS-1:0][AGE_W-1:0] age;
  } set_t;

  function automatic logic [WAYS-1:0][AGE_W-1:0] rst_age();
    logic [WAYS-1:0][AGE_W-1:0] a;
    for (int w = 0; w < WAYS; w++) a[w] = AGE_W'(w);
    return a;
  endfunction

  localparam logic [WAYS-1:0][AGE_W-1:0] RST_AGE = rst_age();

  set_t             mem_q [SETS];
  set_t             p_set_q, p_new;
  logic             p_valid_q;
  logic [KEY_W-1:0] p_key_q;
  logic [VAL_W-1:0] p_op_q;
  logic [IDX_W-1:0] p_idx_q, in_idx;

  logic                       hit, full, p_evict, accept, fwd;
  logic [AGE_W-1:0]           sel;
  logic [WAYS-1:0]            match;
  logic [WAYS-1:0][AGE_W-1:0] age_new;

  fl_state_e        fl_q;
  logic [ENT_W-1:0] fl_ptr_q;
  logic [IDX_W-1:0] fl_set;
  logic [AGE_W-1:0] fl_way;
  logic             fl_step, fl_push;

  logic            push, pop;
  logic [EV_W-1:0] push_data, head;
  logic [FC_W-1:0] fifo_cnt;

  kvc_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
    .key_i(req_key_i),
    .idx_o(in_idx)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign match[w] = (p_set_q.k[w] == p_key_q);
  end

  kvc_way_sel #(.WAYS(WAYS), .AGE_W(AGE_W)) u_way_sel (
    .valid_i(p_set_q.v),
    .match_i(match),
    .age_i  (p_set_q.age),
    .hit_o  (hit),
    .full_o (full),
    .sel_o  (sel),
    .age_o  (age_new)
  );

  // updated image of the set held in the pipeline register
  always_comb begin
    p_new          = p_set_q;
    p_new.age      = age_new;
    p_new.v[sel]   = 1'b1;
    p_new.k[sel]   = p_key_q;
    if (hit) begin
      p_new.val[sel] = p_set_q.val[sel] + p_op_q;
      p_new.cnt[sel] = (&p_set_q.cnt[sel]) ? p_set_q.cnt[sel] : p_set_q.cnt[sel] + 1'b1;
    end else begin
      p_new.val[sel] = INIT_VAL + p_op_q;
      p_new.cnt[sel] = CNT_W'(1);
    end
  end

  assign p_evict     = p_valid_q && !hit && full;
  assign req_ready_o = (fl_q == FL_IDLE) && (fifo_cnt <= FC_W'(FIFO_DEPTH-2));
  assign accept      = req_valid_i && req_ready_o;
  assign fwd         = p_valid_q && (p_idx_q == in_idx);

  assign fl_set  = fl_ptr_q[ENT_W-1:AGE_W];
  assign fl_way  = fl_ptr_q[AGE_W-1:0];
  assign fl_step = (fl_q == FL_WALK) && !p_valid_q && (fifo_cnt != FC_W'(FIFO_DEPTH));
  assign fl_push = fl_step && mem_q[fl_set].v[fl_way];

  assign push      = p_evict || fl_push;
  assign push_data = p_evict ? {p_set_q.k[sel], p_set_q.val[sel], p_set_q.cnt[sel]}
                             : {mem_q[fl_set].k[fl_way], mem_q[fl_set].val[fl_way],
                                mem_q[fl_set].cnt[fl_way]};
  assign pop       = ev_valid_o && ev_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid_q <= 1'b0;
      p_key_q   <= '0;
      p_op_q    <= '0;
      p_idx_q   <= '0;
      p_set_q   <= '0;
    end else begin
      p_valid_q <= accept;
      if (accept) begin
        p_key_q <= req_key_i;
        p_op_q  <= req_op_i;
        p_idx_q <= in_idx;
        p_set_q <= fwd ? p_new : mem_q[in_idx];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        mem_q[s] <= '{v: '0, k: '0, val: '0, cnt: '0, age: RST_AGE};
      end
    end else begin
      if (p_valid_q) mem_q[p_idx_q] <= p_new;
      if (fl_step) begin
        mem_q[fl_set].v[fl_way] <= 1'b0;
        if (fl_ptr_q == ENT_W'(ENT-1)) begin
          for (int s = 0; s < SETS; s++) mem_q[s].age <= RST_AGE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q     <= FL_IDLE;
      fl_ptr_q <= '0;
    end else begin
      case (fl_q)
        FL_IDLE: if (flush_i) begin
          fl_q     <= FL_WALK;
          fl_ptr_q <= '0;
        end
        FL_WALK: if (fl_step) begin
          if (fl_ptr_q == ENT_W'(ENT-1)) fl_q <= FL_IDLE;
          else                           fl_ptr_q <= fl_ptr_q + 1'b1;
        end
        default: fl_q <= FL_IDLE;
      endcase
    end
  end

  kvc_fifo #(.W(EV_W), .DEPTH(FIFO_DEPTH), .CNT_W(FC_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .data_i (push_data),
    .pop_i  (pop),
    .data_o (head),
    .valid_o(ev_valid_o),
    .count_o(fifo_cnt)
  );

  assign {ev_key_o, ev_val_o, ev_cnt_o} = head;
endmodule

// File: rtl/kvc_top_chk.sv
module kvc_top_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int FC_W       = 4,
  parameter int WAYS       = 4,
  parameter int AGE_W      = 2,
  parameter int EV_W       = 72
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_ready_o,
  input logic [FC_W-1:0]            fifo_cnt,
  input logic                       fl_walk,
  input logic                       p_valid,
  input logic                       p_evict,
  input logic [WAYS-1:0]            p_v,
  input logic [WAYS-1:0][AGE_W-1:0] p_ages,
  input logic                       ev_valid_o,
  input logic                       ev_ready_i,
  input logic [EV_W-1:0]            ev_data
);
  logic [WAYS-1:0] oldest;
  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest[w] = (p_ages[w] == AGE_W'(WAYS-1));
  end

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= FC_W'(FIFO_DEPTH));

  assert_ready_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt >= FC_W'(FIFO_DEPTH-1)) |-> !req_ready_o);

  assert_ev_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && !ev_ready_i) |=> (ev_valid_o && $stable(ev_data)));

  assert_flush_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_walk |-> !req_ready_o);

  assert_evict_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_evict |-> (&p_v));

  assert_one_oldest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_valid |-> ($countones(oldest) == 1));
endmodule

bind kvc_top kvc_top_chk #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .FC_W      (FC_W),
  .WAYS      (WAYS),
  .AGE_W     (AGE_W),
  .EV_W      (EV_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .fifo_cnt   (fifo_cnt),
  .fl_walk    (fl_q == FL_WALK),
  .p_valid    (p_valid_q),
  .p_evict    (p_evict),
  .p_v        (p_set_q.v),
  .p_ages     (p_set_q.age),
  .ev_valid_o (ev_valid_o),
  .ev_ready_i (ev_ready_i),
  .ev_data    ({ev_key_o, ev_val_o, ev_cnt_o})
);

// File: tb/kvc_top_bench.sv
module kvc_top_bench;
  localparam int KW = 48;
  localparam int VW = 16;
  localparam int CW = 8;
  localparam logic [VW-1:0] INIT = 16'h0010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [KW-1:0] req_key = '0;
  logic [VW-1:0] req_op = '0;
  logic          flush = 1'b0;
  logic          ev_ready = 1'b1;
  logic          req_ready_o, ev_valid_o;
  logic [KW-1:0] ev_key_o;
  logic [VW-1:0] ev_val_o;
  logic [CW-1:0] ev_cnt_o;

  // 8 time units per period: 125 MHz at 1 ns units
  always #4 clk = ~clk;

  kvc_top u_kvc_top (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_key_i(req_key), .req_op_i(req_op),
    .flush_i(flush),
    .ev_valid_o(ev_valid_o), .ev_ready_i(ev_ready),
    .ev_key_o(ev_key_o), .ev_val_o(ev_val_o), .ev_cnt_o(ev_cnt_o)
  );

  typedef struct {
    logic [KW-1:0] k;
    logic [VW-1:0] v;
    logic [CW-1:0] c;
    string         tag;
  } exp_t;

  exp_t  exp_q[$];
  exp_t  e;
  string cur_tag = "R5";
  int    n_cmp = 0;
  int    n_bad = 0;

  logic          m_v   [4][4];
  logic [KW-1:0] m_k   [4][4];
  logic [VW-1:0] m_val [4][4];
  logic [CW-1:0] m_cnt [4][4];
  int            m_age [4][4];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] bhash(input logic [KW-1:0] k);
    logic [1:0] h = 2'b00;
    for (int i = 0; i < KW; i++) h[i % 2] = h[i % 2] ^ k[i];
    return h;
  endfunction

  function automatic logic [KW-1:0] mkkey(input int id, input int s);
    logic [KW-1:0] k = {16'hC0DE, 24'(id), 8'h00};
    k[1:0] = bhash(k) ^ 2'(s);
    return k;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 1'b0; m_k[s][w] = '0; m_val[s][w] = '0;
        m_cnt[s][w] = '0; m_age[s][w] = w;
      end
  endtask

  task automatic model_req(input logic [KW-1:0] k, input logic [VW-1:0] op);
    int s, sel, a;
    bit hit;
    exp_t x;
    s = int'(bhash(k));
    hit = 1'b0;
    sel = -1;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_k[s][w] == k) begin hit = 1'b1; sel = w; end
    if (!hit) begin
      for (int w = 3; w >= 0; w--) if (!m_v[s][w]) sel = w;
      if (sel < 0) begin
        for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) sel = w;
        x.k = m_k[s][sel]; x.v = m_val[s][sel]; x.c = m_cnt[s][sel]; x.tag = cur_tag;
        exp_q.push_back(x);
      end
    end
    a = m_age[s][sel];
    for (int w = 0; w < 4; w++) begin
      if (w == sel)               m_age[s][w] = 0;
      else if (m_age[s][w] < a)   m_age[s][w] = m_age[s][w] + 1;
    end
    if (hit) begin
      m_val[s][sel] = m_val[s][sel] + op;
      if (m_cnt[s][sel] != 8'hFF) m_cnt[s][sel] = m_cnt[s][sel] + 1'b1;
    end else begin
      m_v[s][sel] = 1'b1; m_k[s][sel] = k;
      m_val[s][sel] = INIT + op; m_cnt[s][sel] = 8'd1;
    end
  endtask

  task automatic model_flush();
    exp_t x;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        if (m_v[s][w]) begin
          x.k = m_k[s][w]; x.v = m_val[s][w]; x.c = m_cnt[s][w]; x.tag = cur_tag;
          exp_q.push_back(x);
        end
        m_v[s][w] = 1'b0;
        m_age[s][w] = w;
      end
  endtask

  // called one unit after a rising edge; leaves req_valid high
  task automatic send(input logic [KW-1:0] k, input logic [VW-1:0] op);
    bit acc;
    req_valid = 1'b1; req_key = k; req_op = op;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = req_ready_o;
      @(posedge clk);
    end
    model_req(k, op);
    #1;
  endtask

  task automatic idle();
    req_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(posedge clk);
    model_flush();
    #1 flush = 1'b0;
    @(negedge clk);
    check(req_ready_o == 1'b0, "R10", "ready during walk", 64'(req_ready_o), 64'd0);
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic wait_drain(input string tag);
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    check(exp_q.size() == 0, tag, "records left undelivered", 64'(exp_q.size()), 64'd0);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ev_valid_o && ev_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected record: actual %h expected none", ev_key_o);
      end else begin
        e = exp_q.pop_front();
        check(ev_key_o == e.k, e.tag, "record key", 64'(ev_key_o), 64'(e.k));
        check(ev_val_o == e.v, e.tag, "record value", 64'(ev_val_o), 64'(e.v));
        check(ev_cnt_o == e.c, e.tag, "record count", 64'(ev_cnt_o), 64'(e.c));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o == 1'b1, "R1", "ready after reset", 64'(req_ready_o), 64'd1);
    check(ev_valid_o == 1'b0, "R1", "no record after reset", 64'(ev_valid_o), 64'd0);
    @(posedge clk); #1;

    // empty store after reset: flush emits nothing
    cur_tag = "R1";
    do_flush();
    repeat (3) @(negedge clk);
    check(ev_valid_o == 1'b0, "R1", "flush of empty store", 64'(ev_valid_o), 64'd0);
    @(posedge clk); #1;

    // set 0: installs, back-to-back hits, LRU eviction
    cur_tag = "R5/R6";
    send(mkkey(1, 0), 16'd1);
    send(mkkey(2, 0), 16'd2);
    send(mkkey(3, 0), 16'd3);
    send(mkkey(4, 0), 16'd4);
    send(mkkey(1, 0), 16'd5);
    send(mkkey(1, 0), 16'd5);
    send(mkkey(2, 0), 16'd1);
    send(mkkey(9, 3), 16'd2);   // R2: other set, no eviction
    send(mkkey(5, 0), 16'd7);   // evicts key 3
    idle();
    check(exp_q.size() == 1 && exp_q[0].k == mkkey(3, 0), "R6", "LRU victim key",
          64'(exp_q[0].k), 64'(mkkey(3, 0)));
    wait_drain("R5");

    // R7/R3: hit sums and counts seen through flush
    cur_tag = "R3/R7";
    do_flush();
    wait_drain("R10");

    // R8: eviction latency
    cur_tag = "R8";
    for (int i = 0; i < 4; i++) send(mkkey(20 + i, 1), 16'(i));
    idle();
    repeat (2) @(posedge clk); #1;
    send(mkkey(30, 1), 16'd9);
    idle();
    @(negedge clk);
    check(ev_valid_o == 1'b0, "R8", "record too early", 64'(ev_valid_o), 64'd0);
    @(negedge clk);
    check(ev_valid_o == 1'b1, "R8", "record due", 64'(ev_valid_o), 64'd1);
    @(posedge clk); #1;
    wait_drain("R8");

    // R9: back-pressure, 8 evictions held, ready drops
    cur_tag = "R9";
    for (int i = 0; i < 4; i++) send(mkkey(40 + i, 2), 16'(i));
    idle();
    repeat (2) @(posedge clk); #1;
    ev_ready = 1'b0;
    for (int i = 0; i < 8; i++) send(mkkey(50 + i, 2), 16'(i + 1));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready_o == 1'b0, "R9", "ready with full queue", 64'(req_ready_o), 64'd0);
    check(ev_valid_o == 1'b1, "R9", "record held", 64'(ev_valid_o), 64'd1);
    @(posedge clk); #1;
    ev_ready = 1'b1;
    wait_drain("R9");

    // mixed traffic across sets with stalls on the eviction side
    cur_tag = "R2/R4/R5";
    lf = 16'hACE1;
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          send(mkkey(int'(lf[3:0]) % 10 + 60, int'(lf[5:4])), 16'(lf[11:8]));
        end
        idle();
      end
      begin
        for (int c = 0; c < 80; c++) begin
          @(posedge clk); #1;
          ev_ready = (c % 3) != 0;
        end
        ev_ready = 1'b1;
      end
    join
    wait_drain("R5");

    cur_tag = "R10";
    do_flush();
    wait_drain("R10");

    // after flush a former key starts afresh (R4)
    cur_tag = "R4";
    send(mkkey(60, 0), 16'd3);
    idle();
    do_flush();
    wait_drain("R4");
    cur_tag = "R10";
    do_flush();
    repeat (4) @(negedge clk);
    check(ev_valid_o == 1'b0, "R10", "flush after clear", 64'(ev_valid_o), 64'd0);
    check(exp_q.size() == 0, "R9", "scoreboard empty", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule